// File: doc/BRIEF.md
# External Bus Idle-State Inserter

This block sits between a source of internal bus requests and the pins of an external memory bus. Each accepted request carries an address, an area number, a read/write direction, a flag marking the target as DRAM space, and a flag choosing a three-state or a two-state access. The block keeps the attributes of the cycle it ran last. From these and from a two-bit enable register it decides whether one dead bus state must come before the new cycle starts. That dead state gives a slow device time to release the data bus before the next device drives it or before the bus itself drives write data.

The block then sequences the external cycle as states T1, T2 and an optional T3. It drives the address, a read strobe, a write strobe, an indication that the dead state is in progress, and a one-cycle completion pulse. A new request can be accepted in the final state of the running cycle, so that cycles follow each other with no gap. A dead state, when one is needed, is the only thing that separates them.

Top module: `bus_idle_inserter`

## Requirements
- R1: A dead state lasts exactly one clock. During it `busIdle` is 1, `rdStrobe`, `wrStrobe` and `cycleDone` are 0, and `busAddr` keeps the address of the previous cycle.
- R2: When `cfgQ[1]` is 1, a read whose area differs from the area of the preceding read is given one dead state. That state comes before the read's T1.
- R3: When `cfgQ[0]` is 1, a write that follows a read is given one dead state.
- R4: When the preceding cycle was to DRAM space (`reqDram` = 1), the next cycle is always given one dead state, whatever the configuration.
- R5: No dead state is inserted in these cases: two reads to the same area; a write after a non-DRAM write; a read after a non-DRAM write; and any case whose rule bit is 0.
- R6: The enable register resets to 2'b11. A cycle with `cfgWe` = 1 loads it from `cfgIn`. Bit 1 enables the different-area read rule and bit 0 enables the write-after-read rule.
- R7: The first access after reset is never given a dead state.
- R8: An access runs T1 (address valid, no strobe), then T2, then T3 only when `reqThree` was 1. In T2 and T3 the strobe is on: `rdStrobe` for a read, `wrStrobe` for a write. The two strobes are never on together.
- R9: `cycleDone` is a one-clock pulse in the final state of each access. `reqReady` is 1 when no cycle runs or in a final state, and 0 otherwise. A request is taken on `reqValid && reqReady`.
- R10: A request taken in a final state starts at the next edge, either with its dead state or with its T1, with no clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Load strobe for the enable register |
| cfgIn | input | 2 | New enable bits: [1] different-area read rule, [0] write-after-read rule |
| reqValid | input | 1 | Request is present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | ADDR_W | Request address |
| reqArea | input | AREA_W | Request area number |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDram | input | 1 | Request targets DRAM space |
| reqThree | input | 1 | 1 = three-state access, 0 = two-state |
| busAddr | output | ADDR_W | External address |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| busIdle | output | 1 | Dead state in progress |
| cycleDone | output | 1 | Final state of an access |

## Verification
The bench builds the block with its defaults, a 16-bit address and a 3-bit area field, and uses areas from 0 to 7. With these values every rule can be exercised under each of the four enable settings. The sequences include DRAM reads and writes followed by reads and by writes, with the rules both on and off. Most accesses run back to back, and two- and three-state accesses are mixed, so the bench can count every state of every access and compare the address held during a dead state with the address of the cycle before it.

// File: rtl/bus_idle_pkg.sv
package bus_idle_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_DEAD,
    ST_T1,
    ST_T2,
    ST_T3
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request address into pending register
    logic loadNow;   // drive request address on the bus at once
    logic loadPend;  // drive pending address on the bus (leaving dead state)
    logic rdOn;
    logic wrOn;
    logic idleOn;
    logic doneOn;
  } dpCtl_t;

endpackage

// File: rtl/bus_idle_ctrl.sv
module bus_idle_ctrl
  import bus_idle_pkg::*;
#(
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgIn,
  input  logic              reqValid,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic              reqDram,
  input  logic              reqThree,
  output logic              reqReady,
  output dpCtl_t            ctl
);

  busState_e state, stateNext;
  logic [1:0] cfgQ;

  // attributes of the most recently accepted cycle
  logic              curValid;
  logic [AREA_W-1:0] curArea;
  logic              curWrite;
  logic              curDram;
  logic              curThree;

  logic lastState;
  logic accept;
  logic needIdle;
  logic ruleArea, ruleDir;

  assign lastState = ((state == ST_T2) && !curThree) || (state == ST_T3);
  assign reqReady  = (state == ST_WAIT) || lastState;
  assign accept    = reqValid && reqReady;

  assign ruleArea = cfgQ[1] && !curWrite && !reqWrite && (curArea != reqArea);
  assign ruleDir  = cfgQ[0] && !curWrite && reqWrite;
  assign needIdle = curValid && (curDram || ruleArea || ruleDir);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_WAIT: if (accept) stateNext = needIdle ? ST_DEAD : ST_T1;
      ST_DEAD: stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2: begin
        if (curThree)    stateNext = ST_T3;
        else if (accept) stateNext = needIdle ? ST_DEAD : ST_T1;
        else             stateNext = ST_WAIT;
      end
      ST_T3: begin
        if (accept) stateNext = needIdle ? ST_DEAD : ST_T1;
        else        stateNext = ST_WAIT;
      end
      default: stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      cfgQ     <= 2'b11;
      curValid <= 1'b0;
      curArea  <= '0;
      curWrite <= 1'b0;
      curDram  <= 1'b0;
      curThree <= 1'b0;
    end else begin
      state <= stateNext;
      if (cfgWe) cfgQ <= cfgIn;
      if (accept) begin
        curValid <= 1'b1;
        curArea  <= reqArea;
        curWrite <= reqWrite;
        curDram  <= reqDram;
        curThree <= reqThree;
      end
    end
  end

  always_comb begin
    ctl.capture  = accept;
    ctl.loadNow  = accept && !needIdle;
    ctl.loadPend = (state == ST_DEAD);
    ctl.rdOn     = ((state == ST_T2) || (state == ST_T3)) && !curWrite;
    ctl.wrOn     = ((state == ST_T2) || (state == ST_T3)) && curWrite;
    ctl.idleOn   = (state == ST_DEAD);
    ctl.doneOn   = lastState;
  end

endmodule

// File: rtl/bus_idle_dp.sv
module bus_idle_dp
  import bus_idle_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              busIdle,
  output logic              cycleDone
);

  logic [ADDR_W-1:0] pendAddr;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      addrQ    <= '0;
    end else begin
      if (ctl.capture)  pendAddr <= reqAddr;
      if (ctl.loadNow)       addrQ <= reqAddr;
      else if (ctl.loadPend) addrQ <= pendAddr;
    end
  end

  assign busAddr   = addrQ;
  assign rdStrobe  = ctl.rdOn;
  assign wrStrobe  = ctl.wrOn;
  assign busIdle   = ctl.idleOn;
  assign cycleDone = ctl.doneOn;

endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import bus_idle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int AREA_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgIn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AREA_W-1:0] reqArea,
  input  logic              reqWrite,
  input  logic              reqDram,
  input  logic              reqThree,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic              busIdle,
  output logic              cycleDone
);

  dpCtl_t ctl;

  bus_idle_ctrl #(.AREA_W(AREA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .reqValid(reqValid), .reqArea(reqArea), .reqWrite(reqWrite),
    .reqDram(reqDram), .reqThree(reqThree),
    .reqReady(reqReady), .ctl(ctl)
  );

  bus_idle_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr),
    .busAddr(busAddr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .busIdle(busIdle), .cycleDone(cycleDone)
  );

endmodule

// File: rtl/bus_idle_checker.sv
module bus_idle_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] busAddr,
  input logic              rdStrobe,
  input logic              wrStrobe,
  input logic              busIdle,
  input logic              cycleDone
);

  assert_idle_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |=> !busIdle);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> (!rdStrobe && !wrStrobe && !cycleDone));

  assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> $stable(busAddr));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> reqReady);

  assert_busy_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStrobe || wrStrobe || busIdle) && !cycleDone) |-> !reqReady);

  assert_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!rdStrobe && !wrStrobe && !cycleDone && !reqReady));

endmodule

bind bus_idle_inserter bus_idle_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busAddr(busAddr), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
  .busIdle(busIdle), .cycleDone(cycleDone)
);

// File: tb/tb_bus_idle_inserter.sv
`timescale 1ns/1ps
module tb_bus_idle_inserter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIn = 2'b00;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic [2:0]  reqArea = '0;
  logic        reqWrite = 1'b0;
  logic        reqDram = 1'b0;
  logic        reqThree = 1'b0;
  logic [15:0] busAddr;
  logic        rdStrobe, wrStrobe, busIdle, cycleDone;

  int total = 0;
  int fails = 0;
  logic [15:0] lastAddr = '0;

  always #2.5 clk = ~clk;

  bus_idle_inserter #(.ADDR_W(16), .AREA_W(3)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqArea(reqArea), .reqWrite(reqWrite), .reqDram(reqDram),
    .reqThree(reqThree), .busAddr(busAddr), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .busIdle(busIdle), .cycleDone(cycleDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input logic [1:0] v);
    cfgIn = v; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Issue one access at a negedge, follow it to its final state and check it.
  task automatic runAccess(input logic [15:0] addr, input logic [2:0] area,
                           input logic wr, input logic dram, input logic three,
                           input int expIdle, input string req);
    logic [15:0] prevAddr;
    int idleSeen, strobeSeen, states, guard;
    bit done, badAddr, badStrobe, badPlace, badReady, badStart;
    prevAddr = lastAddr;
    idleSeen = 0; strobeSeen = 0; states = 0; guard = 0;
    done = 0; badAddr = 0; badStrobe = 0; badPlace = 0; badReady = 0; badStart = 0;
    reqAddr = addr; reqArea = area; reqWrite = wr; reqDram = dram; reqThree = three;
    reqValid = 1'b1;
    while (!reqReady && guard < 20) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 1'b0;
    if (rdStrobe || wrStrobe || cycleDone) badStart = 1;
    while (!done && states < 10) begin
      states++;
      if (busIdle) begin
        idleSeen++;
        if (states != 1) badPlace = 1;
        if (rdStrobe || wrStrobe || cycleDone) badStrobe = 1;
        if (busAddr != prevAddr) badAddr = 1;
      end else begin
        if (busAddr != addr) badAddr = 1;
        if (rdStrobe) begin strobeSeen++; if (wr) badStrobe = 1; end
        if (wrStrobe) begin strobeSeen++; if (!wr) badStrobe = 1; end
      end
      if (!cycleDone && reqReady) badReady = 1;
      if (cycleDone) done = 1;
      else @(negedge clk);
    end
    check(idleSeen == expIdle, req, "dead states", idleSeen, expIdle);
    check(!badPlace, "R2", "dead state before T1", badPlace, 0);
    check(!badAddr, "R1", "address during cycle", busAddr, addr);
    check(!badStrobe, "R8", "strobe kind", badStrobe, 0);
    check(strobeSeen == (three ? 2 : 1), "R8", "strobe states", strobeSeen, three ? 2 : 1);
    check(states == expIdle + (three ? 3 : 2), "R9", "states to cycleDone",
          states, expIdle + (three ? 3 : 2));
    check(!badReady, "R9", "ready held low mid-cycle", badReady, 0);
    check(!badStart, "R10", "first state after accept", badStart, 0);
    lastAddr = addr;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady == 1'b1, "R9", "reset ready", reqReady, 1);
    check(!rdStrobe && !wrStrobe, "R8", "reset strobes", rdStrobe | wrStrobe, 0);
    check(!busIdle && !cycleDone, "R9", "reset idle/done", busIdle | cycleDone, 0);
  endtask

  task automatic testDefaultRules();
    runAccess(16'h1000, 3'd2, 0, 0, 0, 0, "R7");   // first access after reset
    runAccess(16'h2000, 3'd5, 0, 0, 0, 1, "R6");   // reset cfg enables area rule
    runAccess(16'h2004, 3'd5, 0, 0, 1, 0, "R5");   // same-area read
    runAccess(16'h2008, 3'd5, 1, 0, 1, 1, "R3");   // write after read
    runAccess(16'h200C, 3'd5, 1, 0, 0, 0, "R5");   // write after write
    runAccess(16'h0040, 3'd0, 0, 0, 0, 0, "R5");   // read after write
    runAccess(16'h7000, 3'd7, 0, 0, 0, 1, "R2");   // different-area read
  endtask

  task automatic testRulesOff();
    setCfg(2'b00);
    runAccess(16'h3000, 3'd3, 0, 0, 0, 0, "R5");   // area rule off
    runAccess(16'h3010, 3'd3, 1, 0, 0, 0, "R5");   // dir rule off
    runAccess(16'h4000, 3'd4, 0, 1, 1, 0, "R5");   // DRAM read after plain write
    runAccess(16'h4010, 3'd4, 1, 0, 0, 1, "R4");   // after DRAM, rules off
    runAccess(16'h4020, 3'd4, 1, 1, 0, 0, "R5");
    runAccess(16'h4030, 3'd4, 1, 0, 1, 1, "R4");   // write after DRAM write
    repeat (3) @(negedge clk);
    runAccess(16'h4040, 3'd1, 0, 0, 0, 0, "R5");   // after a gap, prev plain write
  endtask

  task automatic testSingleRules();
    setCfg(2'b10);
    runAccess(16'h6000, 3'd6, 0, 0, 0, 1, "R2");   // area rule alone
    runAccess(16'h6010, 3'd6, 1, 0, 0, 0, "R6");   // dir rule cleared
    setCfg(2'b01);
    runAccess(16'h1100, 3'd1, 0, 0, 0, 0, "R5");
    runAccess(16'h1200, 3'd2, 0, 0, 1, 0, "R6");   // area rule cleared
    runAccess(16'h1210, 3'd2, 1, 0, 0, 1, "R3");   // dir rule alone
    setCfg(2'b11);
    runAccess(16'h5000, 3'd5, 0, 1, 0, 0, "R5");
    runAccess(16'h5010, 3'd5, 0, 0, 0, 1, "R4");   // read after DRAM, same area
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDefaultRules();
    testRulesOff();
    testSingleRules();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #50000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule